// File: doc/BRIEF.md
# Interleaved Mismatch Correction Datapath

This block sits after the demodulation step of a multi-channel interleaved converter. It takes the demodulated sample stream one sample per clock. Each sample comes with a cosine-phase reference sample and a channel tag. The block removes the part of the sample that comes from sampling-clock skew, which is the reference scaled by a skew coefficient. It then divides the remainder by the channel gain. No offset subtraction is needed, because demodulation has already cancelled the offset. Skew is corrected by subtracting the scaled quadrature reference, not by resampling or fractional-delay filtering.

An estimator supplies the skew coefficient and the gain coefficient. They are written into a shadow pair, which is copied into the working pair only on a window-boundary strobe. Every sample is therefore corrected with one consistent pair. The datapath is fully pipelined: a multiplier stage, a subtract and magnitude stage, then a restoring divider with one register stage per quotient bit. The quotient is always formed with 8 fraction bits. It is then cut down to the output format (8 integer bits plus 6, 7 or 8 fraction bits, chosen by a parameter) and saturated. The latency is therefore the same for every output format. The channel tag and the valid flag travel along with the data.

Top module: `mismatch_corrector`

## Requirements
- R1: Input formats are fixed. `in_x` is signed with 8 fraction bits. `in_w` and `coef_t` are signed with 14 fraction bits. `coef_g` is unsigned with 14 fraction bits. The skew term is the product coef_t·in_w shifted right arithmetically by 20 (floor), and the difference is in_x minus that term. The output magnitude is floor(|difference|·2^14 / coef_g), which carries 8 fraction bits, shifted right by (8 − OFRAC). The sign of the difference is then applied.
- R2: The result saturates to the range of the OW = 8+OFRAC bit signed output. A negative result below −2^(OW−1) gives −2^(OW−1), a positive result above 2^(OW−1)−1 gives 2^(OW−1)−1, and −2^(OW−1) itself is passed exactly.
- R3: A zero gain coefficient gives the positive limit when the difference is zero or positive, and the negative limit when it is negative.
- R4: A sample presented with `in_valid` in cycle k appears with `out_valid` in cycle k+35 with the default widths. This latency is the same for OFRAC of 6, 7 and 8.
- R5: The block accepts a sample in every clock. Each valid input gives exactly one valid output, in input order.
- R6: `out_tag` equals the `in_tag` presented with the sample that produced the output.
- R7: A write through `coef_wr` loads only the shadow pair. Samples keep using the working pair until the next `win_swap`.
- R8: A sample presented in the same cycle as `win_swap` uses the working pair in force before the swap. Later samples use the copied shadow pair. A `coef_wr` in the swap cycle is not part of that copy.
- R9: After reset `out_valid` and `out_data` are 0. The working pair is skew 0 and gain 1.0 (16384).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_x | input | DW | Demodulated sample, signed, 8 fraction bits |
| in_w | input | WW | Cosine-phase reference sample, signed, 14 fraction bits |
| in_tag | input | CHW | Channel tag, passed through |
| coef_wr | input | 1 | Load the shadow coefficient pair |
| coef_t | input | TW | Skew coefficient for the shadow pair, signed |
| coef_g | input | GW | Gain coefficient for the shadow pair, unsigned |
| win_swap | input | 1 | Window boundary: copy the shadow pair into the working pair |
| out_valid | output | 1 | Corrected sample present |
| out_tag | output | CHW | Tag of the corrected sample |
| out_data | output | 8+OFRAC | Corrected sample, signed, saturated |

## Verification
The latency and tag properties compare the outputs against a shift-register copy of `in_valid` and `in_tag`. These properties therefore assume both inputs are always known after reset. The swap properties assume `win_swap` is known in every cycle. The bench drives every input at the falling edge from reset onward, using fixed values and never X, and holds them idle at zero between samples. The sign property assumes the gain is never close enough to zero to push a small magnitude past the limit the wrong way. The bench checks the zero-gain cases separately at the ports.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
  localparam int OINT  = 8;  // integer bits of the output format
  localparam int QFRAC = 8;  // fraction bits produced by the divider

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mcd_coef_bank.sv
module mcd_coef_bank #(
  parameter int TW    = 16,
  parameter int GW    = 16,
  parameter int GFRAC = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [TW-1:0] t_wr,
  input  logic [GW-1:0] g_wr,
  input  logic          swap,
  output logic [TW-1:0] t_act,
  output logic [GW-1:0] g_act,
  output logic [TW-1:0] t_shd,
  output logic [GW-1:0] g_shd
);
  localparam logic [GW-1:0] GONE = GW'(64'd1 << GFRAC);

  // shadow pair: written by the estimator at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_shd <= '0;
      g_shd <= GONE;
    end else if (wr_en) begin
      t_shd <= t_wr;
      g_shd <= g_wr;
    end
  end

  // working pair: changes only on a window boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_act <= '0;
      g_act <= GONE;
    end else if (swap) begin
      t_act <= t_shd;
      g_act <= g_shd;
    end
  end
endmodule

// File: rtl/mcd_skew_front.sv
module mcd_skew_front #(
  parameter int DW   = 16,
  parameter int WW   = 16,
  parameter int TW   = 16,
  parameter int GW   = 16,
  parameter int CHW  = 2,
  parameter int SH   = 20,
  parameter int DIFW = 17
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_x,
  input  logic [WW-1:0]   in_w,
  input  logic [CHW-1:0]  in_tag,
  input  logic [TW-1:0]   t_act,
  input  logic [GW-1:0]   g_act,
  output logic            o_valid,
  output logic [CHW-1:0]  o_tag,
  output logic            o_neg,
  output logic [DIFW-1:0] o_mag,
  output logic [GW-1:0]   o_g
);
  localparam int PW = TW + WW;

  // stage 0: capture sample together with its coefficient pair
  logic                 v0;
  logic signed [DW-1:0] x0;
  logic signed [WW-1:0] w0;
  logic signed [TW-1:0] t0;
  logic [GW-1:0]        g0;
  logic [CHW-1:0]       tag0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v0 <= 1'b0; x0 <= '0; w0 <= '0; t0 <= '0; g0 <= '0; tag0 <= '0;
    end else begin
      v0 <= in_valid; x0 <= in_x; w0 <= in_w; t0 <= t_act; g0 <= g_act; tag0 <= in_tag;
    end
  end

  // stage 1: skew product
  logic                 v1;
  logic signed [DW-1:0] x1;
  logic signed [PW-1:0] prod1;
  logic [GW-1:0]        g1;
  logic [CHW-1:0]       tag1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1 <= 1'b0; x1 <= '0; prod1 <= '0; g1 <= '0; tag1 <= '0;
    end else begin
      v1 <= v0; x1 <= x0; prod1 <= t0 * w0; g1 <= g0; tag1 <= tag0;
    end
  end

  // stage 2: subtract, split into sign and magnitude
  logic signed [PW-1:0]   term_c;
  logic signed [DIFW-1:0] diff_c;
  logic [DIFW-1:0]        mag_c;

  always_comb begin
    term_c = prod1 >>> SH;
    diff_c = DIFW'(x1) - DIFW'(term_c);
    mag_c  = diff_c[DIFW-1] ? DIFW'(-diff_c) : DIFW'(diff_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0; o_tag <= '0; o_neg <= 1'b0; o_mag <= '0; o_g <= '0;
    end else begin
      o_valid <= v1; o_tag <= tag1; o_neg <= diff_c[DIFW-1]; o_mag <= mag_c; o_g <= g1;
    end
  end
endmodule

// File: rtl/mcd_div_step.sv
module mcd_div_step #(
  parameter int NUMW = 31,
  parameter int GW   = 16,
  parameter int CHW  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            i_valid,
  input  logic [CHW-1:0]  i_tag,
  input  logic            i_neg,
  input  logic [GW-1:0]   i_d,
  input  logic [GW-1:0]   i_rem,
  input  logic [NUMW-1:0] i_num,
  input  logic [NUMW-1:0] i_quot,
  output logic            o_valid,
  output logic [CHW-1:0]  o_tag,
  output logic            o_neg,
  output logic [GW-1:0]   o_d,
  output logic [GW-1:0]   o_rem,
  output logic [NUMW-1:0] o_num,
  output logic [NUMW-1:0] o_quot
);
  logic [GW:0]   trial;
  logic [GW:0]   less;
  logic          take;
  logic [GW-1:0] rem_n;

  // one restoring step: bring down the next numerator bit, try the divisor
  always_comb begin
    trial = {i_rem, i_num[NUMW-1]};
    less  = trial - {1'b0, i_d};
    take  = (trial >= {1'b0, i_d});
    rem_n = take ? less[GW-1:0] : trial[GW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0; o_tag <= '0; o_neg <= 1'b0; o_d <= '0;
      o_rem <= '0; o_num <= '0; o_quot <= '0;
    end else begin
      o_valid <= i_valid;
      o_tag   <= i_tag;
      o_neg   <= i_neg;
      o_d     <= i_d;
      o_rem   <= rem_n;
      o_num   <= {i_num[NUMW-2:0], 1'b0};
      o_quot  <= {i_quot[NUMW-2:0], take};
    end
  end
endmodule

// File: rtl/mismatch_corrector.sv
module mismatch_corrector #(
  parameter int DW    = 16,
  parameter int XFRAC = 8,
  parameter int WW    = 16,
  parameter int WFRAC = 14,
  parameter int TW    = 16,
  parameter int TFRAC = 14,
  parameter int GW    = 16,
  parameter int GFRAC = 14,
  parameter int OFRAC = 8,
  parameter int CHW   = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_valid,
  input  logic [DW-1:0]                    in_x,
  input  logic [WW-1:0]                    in_w,
  input  logic [CHW-1:0]                   in_tag,
  input  logic                             coef_wr,
  input  logic [TW-1:0]                    coef_t,
  input  logic [GW-1:0]                    coef_g,
  input  logic                             win_swap,
  output logic                             out_valid,
  output logic [CHW-1:0]                   out_tag,
  output logic [mcd_pkg::OINT+OFRAC-1:0]   out_data
);
  localparam int OW      = mcd_pkg::OINT + OFRAC;
  localparam int PW      = TW + WW;
  localparam int SH      = TFRAC + WFRAC - XFRAC;
  localparam int DIFW    = mcd_pkg::max2(DW, PW - SH) + 1;
  localparam int PRE     = GFRAC + mcd_pkg::QFRAC - XFRAC;
  localparam int NUMW    = DIFW + PRE;
  localparam int LATENCY = NUMW + 4;
  localparam int DROP    = mcd_pkg::QFRAC - OFRAC;
  localparam logic [NUMW-1:0] LIM_POS = NUMW'((64'd1 << (OW - 1)) - 64'd1);
  localparam logic [NUMW-1:0] LIM_NEG = NUMW'(64'd1 << (OW - 1));

  // reduce the 8-fraction-bit magnitude to the output format and clamp
  function automatic logic [OW-1:0] fmt_sat(input logic [NUMW-1:0] q, input logic neg);
    logic [NUMW-1:0] qs;
    logic [OW-1:0]   r;
    qs = q >> DROP;
    if (neg) r = (qs > LIM_NEG) ? {1'b1, {(OW-1){1'b0}}} : OW'(~qs + NUMW'(1));
    else     r = (qs > LIM_POS) ? {1'b0, {(OW-1){1'b1}}} : qs[OW-1:0];
    return r;
  endfunction

  // coefficient double buffer
  logic [TW-1:0] act_t, shd_t;
  logic [GW-1:0] act_g, shd_g;

  mcd_coef_bank #(.TW(TW), .GW(GW), .GFRAC(GFRAC)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(coef_wr), .t_wr(coef_t), .g_wr(coef_g),
    .swap(win_swap), .t_act(act_t), .g_act(act_g), .t_shd(shd_t), .g_shd(shd_g)
  );

  // skew removal front end
  logic            fe_valid, fe_neg;
  logic [CHW-1:0]  fe_tag;
  logic [DIFW-1:0] fe_mag;
  logic [GW-1:0]   fe_g;

  mcd_skew_front #(.DW(DW), .WW(WW), .TW(TW), .GW(GW), .CHW(CHW), .SH(SH), .DIFW(DIFW)) u_front (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_w(in_w), .in_tag(in_tag),
    .t_act(act_t), .g_act(act_g), .o_valid(fe_valid), .o_tag(fe_tag), .o_neg(fe_neg),
    .o_mag(fe_mag), .o_g(fe_g)
  );

  // restoring divider, one stage per quotient bit
  logic            dv_v   [NUMW+1];
  logic [CHW-1:0]  dv_tag [NUMW+1];
  logic            dv_neg [NUMW+1];
  logic [GW-1:0]   dv_d   [NUMW+1];
  logic [GW-1:0]   dv_rem [NUMW+1];
  logic [NUMW-1:0] dv_num [NUMW+1];
  logic [NUMW-1:0] dv_q   [NUMW+1];

  assign dv_v[0]   = fe_valid;
  assign dv_tag[0] = fe_tag;
  assign dv_neg[0] = fe_neg;
  assign dv_d[0]   = fe_g;
  assign dv_rem[0] = '0;
  assign dv_num[0] = {fe_mag, {PRE{1'b0}}};
  assign dv_q[0]   = '0;

  for (genvar s = 0; s < NUMW; s++) begin : g_div
    mcd_div_step #(.NUMW(NUMW), .GW(GW), .CHW(CHW)) u_step (
      .clk(clk), .rst_n(rst_n),
      .i_valid(dv_v[s]), .i_tag(dv_tag[s]), .i_neg(dv_neg[s]), .i_d(dv_d[s]),
      .i_rem(dv_rem[s]), .i_num(dv_num[s]), .i_quot(dv_q[s]),
      .o_valid(dv_v[s+1]), .o_tag(dv_tag[s+1]), .o_neg(dv_neg[s+1]), .o_d(dv_d[s+1]),
      .o_rem(dv_rem[s+1]), .o_num(dv_num[s+1]), .o_quot(dv_q[s+1])
    );
  end

  // named event for the checker: sign leaving the divider
  logic tail_neg;
  assign tail_neg = dv_neg[NUMW];

  logic unused_tail;
  assign unused_tail = ^{dv_rem[NUMW], dv_num[NUMW], dv_d[NUMW]};

  // output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_tag   <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= dv_v[NUMW];
      out_tag   <= dv_tag[NUMW];
      out_data  <= fmt_sat(dv_q[NUMW], dv_neg[NUMW]);
    end
  end
endmodule

// File: rtl/mismatch_corrector_chk.sv
module mismatch_corrector_chk #(
  parameter int LAT = 35,
  parameter int CHW = 2,
  parameter int TW  = 16,
  parameter int GW  = 16,
  parameter int OW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [CHW-1:0] in_tag,
  input logic           out_valid,
  input logic [CHW-1:0] out_tag,
  input logic [OW-1:0]  out_data,
  input logic           win_swap,
  input logic [TW-1:0]  act_t,
  input logic [GW-1:0]  act_g,
  input logic [TW-1:0]  shd_t,
  input logic [GW-1:0]  shd_g,
  input logic           tail_neg
);
  // reference delay line for valid and tag
  logic [LAT-1:0] vsh;
  logic [CHW-1:0] tsh [LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vsh <= '0;
      for (int i = 0; i < LAT; i++) tsh[i] <= '0;
    end else begin
      vsh <= {vsh[LAT-2:0], in_valid};
      tsh[0] <= in_tag;
      for (int i = 1; i < LAT; i++) tsh[i] <= tsh[i-1];
    end
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == vsh[LAT-1]);

  p_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_tag == tsh[LAT-1]));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !win_swap |=> ($stable(act_t) && $stable(act_g)));

  p_swap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_swap |=> ((act_t == $past(shd_t)) && (act_g == $past(shd_g))));

  p_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_data != '0)) |-> (out_data[OW-1] == $past(tail_neg)));
endmodule

bind mismatch_corrector mismatch_corrector_chk #(
  .LAT(LATENCY), .CHW(CHW), .TW(TW), .GW(GW), .OW(OW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_tag(in_tag),
  .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data),
  .win_swap(win_swap), .act_t(act_t), .act_g(act_g), .shd_t(shd_t), .shd_g(shd_g),
  .tail_neg(tail_neg)
);

// File: tb/mismatch_corrector_test.sv
module mismatch_corrector_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT_EXP    = 35;

  // vectors: {x, w, t, g}
  localparam logic [63:0] VEC [14] = '{
    64'h0100_0000_0000_4000,
    64'hFF00_2000_0400_4000,
    64'h1234_C000_0A00_3000,
    64'h7FFF_0000_0000_2000, // R2 positive clamp
    64'h8000_0000_0000_2000, // R2 negative clamp
    64'h8000_0000_0000_4000, // R2 exact negative limit
    64'h0300_7FFF_7FFF_4000,
    64'h0050_8000_7FFF_5000,
    64'h0000_0000_0000_0000, // R3 zero gain, zero diff
    64'hFFFF_0000_0000_0000, // R3 zero gain, negative diff
    64'h0ABC_1111_F000_6000,
    64'hF123_4567_1234_7FFF,
    64'h0001_0000_0000_FFFF,
    64'hFFFF_0000_0000_FFFF
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [15:0] in_x = '0, in_w = '0, coef_t = '0, coef_g = '0;
  logic [1:0] in_tag = '0;
  logic coef_wr = 1'b0, win_swap = 1'b0;

  logic ov8, ov7, ov6;
  logic [1:0] ot8, ot7, ot6;
  logic [15:0] o8;
  logic [14:0] o7;
  logic [13:0] o6;

  always #(CLK_PERIOD/2) clk = ~clk;

  mismatch_corrector #(.OFRAC(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_w(in_w), .in_tag(in_tag),
    .coef_wr(coef_wr), .coef_t(coef_t), .coef_g(coef_g), .win_swap(win_swap),
    .out_valid(ov8), .out_tag(ot8), .out_data(o8));
  mismatch_corrector #(.OFRAC(7)) uut_f7 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_w(in_w), .in_tag(in_tag),
    .coef_wr(coef_wr), .coef_t(coef_t), .coef_g(coef_g), .win_swap(win_swap),
    .out_valid(ov7), .out_tag(ot7), .out_data(o7));
  mismatch_corrector #(.OFRAC(6)) uut_f6 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_x(in_x), .in_w(in_w), .in_tag(in_tag),
    .coef_wr(coef_wr), .coef_t(coef_t), .coef_g(coef_g), .win_swap(win_swap),
    .out_valid(ov6), .out_tag(ot6), .out_data(o6));

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  // bench model of the coefficient pairs
  logic [15:0] m_t = 16'h0000, m_g = 16'h4000, s_t = 16'h0000, s_g = 16'h4000;

  longint e8 [512];
  longint e7 [512];
  longint e6 [512];
  logic [1:0] etag [512];
  string elab [512];
  int wr_ix = 0;
  int rd_ix = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected corrected value, restated from the requirements
  function automatic longint model(input logic [15:0] x, w, t, g, input int ofrac);
    longint term, diff, mag, q, lim;
    bit neg;
    term = (longint'($signed(t)) * longint'($signed(w))) >>> 20;
    diff = longint'($signed(x)) - term;
    neg  = diff < 0;
    mag  = neg ? -diff : diff;
    if (g == 0) q = longint'(1) << 40;
    else        q = (mag * 16384) / longint'(g);
    q   = q >> (8 - ofrac);
    lim = longint'(1) << (8 + ofrac - 1);
    if (neg) return (q > lim) ? -lim : -q;
    else     return (q > lim - 1) ? lim - 1 : q;
  endfunction

  task automatic cyc(input logic v, input logic [15:0] x, w, input logic [1:0] tag,
                     input logic wr, input logic [15:0] t, g, input logic sw, input string lab);
    @(negedge clk);
    in_valid = v; in_x = x; in_w = w; in_tag = tag;
    coef_wr = wr; coef_t = t; coef_g = g; win_swap = sw;
    if (v) begin
      e8[wr_ix] = model(x, w, m_t, m_g, 8);
      e7[wr_ix] = model(x, w, m_t, m_g, 7);
      e6[wr_ix] = model(x, w, m_t, m_g, 6);
      etag[wr_ix] = tag;
      elab[wr_ix] = lab;
      wr_ix++;
    end
    if (sw) begin m_t = s_t; m_g = s_g; end
    if (wr) begin s_t = t; s_g = g; end
  endtask

  task automatic idle();
    cyc(1'b0, '0, '0, 2'd0, 1'b0, '0, '0, 1'b0, "");
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && (ov8 || ov7 || ov6)) begin
      chk(ov8 && ov7 && ov6, "R4 valid alike across formats", {ov6, ov7, ov8}, 3'b111);
      if (rd_ix < wr_ix) begin
        chk(longint'($signed(o8)) == e8[rd_ix], elab[rd_ix], longint'($signed(o8)), e8[rd_ix]);
        chk(longint'($signed(o7)) == e7[rd_ix], elab[rd_ix], longint'($signed(o7)), e7[rd_ix]);
        chk(longint'($signed(o6)) == e6[rd_ix], elab[rd_ix], longint'($signed(o6)), e6[rd_ix]);
        chk(ot8 == etag[rd_ix] && ot6 == etag[rd_ix], "R6 tag", ot8, etag[rd_ix]);
      end else begin
        chk(1'b0, "R5 output without input", rd_ix, wr_ix);
      end
      rd_ix++;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk(!ov8 && !ov7 && !ov6, "R9 out_valid in reset", ov8, 0);
    chk(o8 == 0 && o7 == 0 && o6 == 0, "R9 out_data in reset", o8, 0);
    rst_n = 1'b1;

    // R9 default working pair: skew 0, gain 1.0
    cyc(1'b1, 16'h0180, 16'h2000, 2'd1, 1'b0, '0, '0, 1'b0, "R9 default pair");
    cyc(1'b1, 16'hFE40, 16'h7000, 2'd2, 1'b0, '0, '0, 1'b0, "R9 default pair");

    // vector table walk: load shadow, swap, send sample
    for (int i = 0; i < 14; i++) begin
      string lab;
      lab = (i >= 3 && i <= 5) ? "R2 clamp" : ((i == 8 || i == 9) ? "R3 zero gain" : "R1 value");
      cyc(1'b0, '0, '0, 2'd0, 1'b1, VEC[i][31:16], VEC[i][15:0], 1'b0, "");
      cyc(1'b0, '0, '0, 2'd0, 1'b0, '0, '0, 1'b1, "");
      cyc(1'b1, VEC[i][63:48], VEC[i][47:32], 2'(i), 1'b0, '0, '0, 1'b0, lab);
    end

    // R7: shadow write alone leaves working pair in force
    cyc(1'b0, '0, '0, 2'd0, 1'b1, 16'h2000, 16'h8000, 1'b0, "");
    cyc(1'b1, 16'h0400, 16'h4000, 2'd3, 1'b0, '0, '0, 1'b0, "R7 shadow write ignored");
    cyc(1'b1, 16'hFC00, 16'hC000, 2'd0, 1'b0, '0, '0, 1'b0, "R7 shadow write ignored");

    // R8: sample + swap + new write in one cycle
    cyc(1'b1, 16'h0400, 16'h4000, 2'd1, 1'b1, 16'hE000, 16'h2800, 1'b1, "R8 swap cycle uses old pair");
    cyc(1'b1, 16'h0400, 16'h4000, 2'd2, 1'b0, '0, '0, 1'b0, "R8 after swap");
    cyc(1'b0, '0, '0, 2'd0, 1'b0, '0, '0, 1'b1, "");
    cyc(1'b1, 16'h0400, 16'h4000, 2'd3, 1'b0, '0, '0, 1'b0, "R8 second swap");

    // R5: back-to-back stream
    for (int k = 0; k < 24; k++) begin
      cyc(1'b1, 16'(k * 1237 - 9000), 16'(k * 3001 - 30000), 2'(k * 3), 1'b0, '0, '0, 1'b0,
          "R5 stream");
    end

    // R4: latency of a lone sample
    repeat (40) idle();
    cyc(1'b1, 16'h0200, 16'h1000, 2'd2, 1'b0, '0, '0, 1'b0, "R4 lone sample");
    n = 0;
    do begin
      idle();
      n++;
    end while (!ov8 && n < 60);
    chk(n == LAT_EXP, "R4 latency", n, LAT_EXP);
    chk(ov6 && ov7, "R4 latency alike across formats", {ov6, ov7}, 2'b11);

    repeat (40) idle();
    chk(rd_ix == wr_ix, "R5 output count", rd_ix, wr_ix);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule